// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block drives a multiplexed liquid-crystal panel of four common lines and 26 segment lines. It keeps one nibble of display memory per segment, steps through the commons one time slot at a time, and for every common and segment pin produces a 2-bit code that picks one of the bias voltage levels. Analog circuitry outside the block turns those codes into voltages. Polarity flips on every frame so that each pixel sees zero average voltage.

Two drive schemes can be chosen at run time: four commons at one-third bias, or three commons at one-half bias. A write-only register port loads the display memory, a control word (scheme select, display off, port reuse) and a port data nibble. When port reuse is on, the first four segment pins act as plain digital outputs. A single-cycle `frame_tick` input sets the pace of the scan.

Top module: `lcd_scan`

## Requirements
- R1: After reset the scheme is three commons at one-half bias, the slot is 0 and the polarity is even. All memory is clear. COM1 (index 0) outputs code 2, the other commons output code 1, and every segment outputs code 2.
- R2: Writing address s (0..25) stores `wr_data` as the nibble of segment s, where bit k belongs to common k (index 0 = COM1). Address 26 is the control word: bit0 = 1 selects four-common one-third bias and 0 selects three-common one-half bias, bit1 = 1 turns the display off, and bit2 = 1 enables port reuse. Address 27 stores the port data, where bit k drives segment k. Writes to any other address change nothing.
- R3: Each `frame_tick` advances the slot by one. After slot 3 (four-common scheme) or slot 2 (three-common scheme) the slot wraps to 0 and the polarity toggles. With no tick, both slot and polarity hold.
- R4: In the four-common scheme, with T = 3: on even polarity the active common outputs 3 and the others output 1; on odd polarity the active common outputs 0 and the others output 2.
- R5: In the four-common scheme, a lit segment outputs 0 on even polarity and 3 on odd polarity. An unlit segment outputs 2 on even polarity and 1 on odd polarity.
- R6: In the three-common scheme, with T = 2: the active common outputs 2 on even polarity and 0 on odd polarity, and the others output 1. A lit segment outputs 0 or 2, an unlit segment outputs 2 or 0 (even or odd polarity), and code 3 never appears on any pin.
- R7: In the three-common scheme, bit 3 of every nibble has no effect on any output.
- R8: The nibble bit for the active common is captured at the `frame_tick` that opens the slot. A memory write during a slot changes no output until the next tick.
- R9: With the display off, every common and every segment not in port use outputs code 0, and the slot and polarity keep advancing.
- R10: With port reuse on, segments 0..3 output T when their port data bit is 1 and 0 when it is 0. This holds whatever the display memory holds and whether or not the display is off. The other segments are unaffected.
- R11: If the scheme changes to three commons while the slot is 3, the next tick wraps the slot to 0 and toggles the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 4 | Register write data |
| frame_tick | input | 1 | One-cycle pulse that advances the common slot |
| com_lvl | output | 8 | Level codes, 2 bits per common, COM1 in bits 1:0 |
| seg_lvl | output | 52 | Level codes, 2 bits per segment, segment 0 in bits 1:0 |

## Verification
The bench runs whole frames in both schemes over several memory patterns: a diagonal, all-lit, all-unlit and an alternating pattern. It compares every pin against levels worked out arithmetically. This separates common from segment coding, lit from unlit, and even from odd polarity. In the three-common scheme the patterns deliberately set the COM4 bit to show that it is ignored. Separate runs cover the following:
- all 16 port data values, with the display on and with it off;
- writes made in the middle of a slot;
- writes to unused addresses;
- a change of scheme while the slot is 3.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic port_mode;
    logic off;
    logic duty4;
  } ctrl_t;

  function automatic lvl_t top_lvl(input logic duty4);
    return duty4 ? lvl_t'(3) : lvl_t'(2);
  endfunction

  function automatic lvl_t polar(input lvl_t base, input logic duty4, input logic odd);
    return odd ? lvl_t'(top_lvl(duty4) - base) : base;
  endfunction
endpackage

// File: rtl/lcd_scan_regs.sv
module lcd_scan_regs
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG   = 26,
  parameter int NUM_COM   = 4,
  parameter int PORT_SEGS = 4,
  parameter int ADDR_W    = 5,
  parameter int SLOT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_COM-1:0]   wr_data,
  input  logic [SLOT_W-1:0]    rd_slot,
  output logic [NUM_SEG-1:0]   col,
  output ctrl_t                ctrl_q,
  output logic [PORT_SEGS-1:0] port_q
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SEG);
  localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(NUM_SEG + 1);

  logic [NUM_COM-1:0] mem_q [NUM_SEG];
  logic [NUM_COM-1:0] mem_d [NUM_SEG];
  ctrl_t              ctrl_d;
  logic [PORT_SEGS-1:0] port_d;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_mem
    always_comb begin
      mem_d[s] = mem_q[s];
      if (wr_en && (wr_addr == ADDR_W'(s))) mem_d[s] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[s] <= '0;
      else        mem_q[s] <= mem_d[s];
    end
    assign col[s] = mem_q[s][rd_slot];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    port_d = port_q;
    if (wr_en && (wr_addr == CTRL_ADDR)) ctrl_d = ctrl_t'(wr_data[2:0]);
    if (wr_en && (wr_addr == PORT_ADDR)) port_d = wr_data[PORT_SEGS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      port_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      port_q <= port_d;
    end
  end

  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr != CTRL_ADDR) |=> $stable(ctrl_q)); // R2
  AST_PORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr != PORT_ADDR) |=> $stable(port_q)); // R2
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
  parameter int NUM_COM = 4,
  parameter int SLOT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              duty4,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_d,
  output logic              odd_q
);
  localparam logic [SLOT_W-1:0] LAST4 = SLOT_W'(NUM_COM - 1);
  localparam logic [SLOT_W-1:0] LAST3 = SLOT_W'(NUM_COM - 2);

  logic [SLOT_W-1:0] last;
  logic              wrap;
  logic              odd_d;

  always_comb begin
    last   = duty4 ? LAST4 : LAST3;
    wrap   = tick && (slot_q >= last);
    slot_d = slot_q;
    odd_d  = odd_q;
    if (tick) begin
      slot_d = wrap ? '0 : slot_q + SLOT_W'(1);
      odd_d  = odd_q ^ wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      odd_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      odd_q  <= odd_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(slot_q) && $stable(odd_q))); // R3
  AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot_q >= last) |=> (slot_q == '0 && odd_q != $past(odd_q))); // R11
  AST_THIRD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !duty4) |=> (slot_q <= LAST3)); // R3
endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG   = 26,
  parameter int NUM_COM   = 4,
  parameter int PORT_SEGS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [NUM_SEG-1:0]       col_next,
  input  logic [SLOT_W-1:0]        slot_q,
  input  logic                     odd_q,
  input  ctrl_t                    ctrl_q,
  input  logic [PORT_SEGS-1:0]     port_q,
  output logic [NUM_COM*LVL_W-1:0] com_lvl,
  output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);
  logic [NUM_SEG-1:0] lit_q;
  logic [NUM_SEG-1:0] lit_d;
  lvl_t               top;

  always_comb begin
    lit_d = tick ? col_next : lit_q;
    top   = top_lvl(ctrl_q.duty4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lit_q <= '0;
    else        lit_q <= lit_d;
  end

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    lvl_t base;
    always_comb begin
      base = (slot_q == SLOT_W'(i)) ? top : lvl_t'(1);
      com_lvl[i*LVL_W +: LVL_W] = ctrl_q.off ? lvl_t'(0) : polar(base, ctrl_q.duty4, odd_q);
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    lvl_t base;
    lvl_t lcd;
    always_comb begin
      base = lit_q[s] ? lvl_t'(0) : lvl_t'(2);
      lcd  = ctrl_q.off ? lvl_t'(0) : polar(base, ctrl_q.duty4, odd_q);
    end
    if (s < PORT_SEGS) begin : g_port
      assign seg_lvl[s*LVL_W +: LVL_W] =
        ctrl_q.port_mode ? (port_q[s] ? top : lvl_t'(0)) : lcd;
    end else begin : g_lcd
      assign seg_lvl[s*LVL_W +: LVL_W] = lcd;
    end
  end

  logic [NUM_COM-1:0] com_sel;
  logic [NUM_COM-1:0] com_hi;
  logic [NUM_SEG-1:0] seg_hi;
  logic [PORT_SEGS-1:0] port_bad;
  for (genvar i = 0; i < NUM_COM; i++) begin : g_chk_com
    assign com_sel[i] = com_lvl[i*LVL_W +: LVL_W] == (odd_q ? lvl_t'(0) : top);
    assign com_hi[i]  = com_lvl[i*LVL_W +: LVL_W] == lvl_t'(3);
  end
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_chk_seg
    assign seg_hi[s] = seg_lvl[s*LVL_W +: LVL_W] == lvl_t'(3);
  end
  for (genvar s = 0; s < PORT_SEGS; s++) begin : g_chk_port
    assign port_bad[s] = (seg_lvl[s*LVL_W +: LVL_W] != lvl_t'(0)) &&
                         (seg_lvl[s*LVL_W +: LVL_W] != top);
  end

  AST_OFF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.off |-> (com_lvl == '0)); // R9
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.off |-> ($countones(com_sel) == 1)); // R4
  AST_HALF_NO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.duty4 |-> ((com_hi == '0) && (seg_hi == '0))); // R6
  AST_PORT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.port_mode |-> (port_bad == '0)); // R10
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG   = 26,
  parameter int NUM_COM   = 4,
  parameter int PORT_SEGS = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NUM_COM-1:0]       wr_data,
  input  logic                     frame_tick,
  output logic [NUM_COM*LVL_W-1:0] com_lvl,
  output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);
  localparam int SLOT_W = $clog2(NUM_COM);

  logic [SLOT_W-1:0]    slot_q;
  logic [SLOT_W-1:0]    slot_d;
  logic                 odd_q;
  logic [NUM_SEG-1:0]   col_next;
  ctrl_t                ctrl_q;
  logic [PORT_SEGS-1:0] port_q;

  lcd_scan_regs #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .PORT_SEGS(PORT_SEGS),
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_slot(slot_d), .col(col_next),
    .ctrl_q(ctrl_q), .port_q(port_q)
  );

  lcd_scan_timing #(.NUM_COM(NUM_COM), .SLOT_W(SLOT_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .duty4(ctrl_q.duty4),
    .slot_q(slot_q), .slot_d(slot_d), .odd_q(odd_q)
  );

  lcd_scan_drive #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .PORT_SEGS(PORT_SEGS), .SLOT_W(SLOT_W)
  ) u_drive (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .col_next(col_next),
    .slot_q(slot_q), .odd_q(odd_q), .ctrl_q(ctrl_q), .port_q(port_q),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: tb/lcd_scan_tb.sv
module lcd_scan_tb;
  localparam int NSEG = 26;
  localparam int NCOM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic frame_tick = 1'b0;
  logic [2*NCOM-1:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [3:0] m_ram [NSEG];
  logic [NSEG-1:0] m_lit;
  int m_slot, m_odd, m_duty, m_off, m_port;
  logic [3:0] m_pdat;

  lcd_scan u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_tick(frame_tick),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  always #2 clk = ~clk;

  function automatic int top_v();
    return m_duty ? 3 : 2;
  endfunction

  function automatic logic [2*NCOM-1:0] exp_com();
    logic [2*NCOM-1:0] v = '0;
    for (int i = 0; i < NCOM; i++) begin
      int b = (i == m_slot) ? top_v() : 1;
      int l = m_off ? 0 : (m_odd ? top_v() - b : b);
      v[2*i +: 2] = 2'(l);
    end
    return v;
  endfunction

  function automatic logic [2*NSEG-1:0] exp_seg();
    logic [2*NSEG-1:0] v = '0;
    for (int s = 0; s < NSEG; s++) begin
      int b = m_lit[s] ? 0 : 2;
      int l = m_off ? 0 : (m_odd ? top_v() - b : b);
      if (m_port && s < 4) l = m_pdat[s] ? top_v() : 0;
      v[2*s +: 2] = 2'(l);
    end
    return v;
  endfunction

  task automatic check(input string tag);
    logic [2*NCOM-1:0] ec = exp_com();
    logic [2*NSEG-1:0] es = exp_seg();
    n_run++;
    if (com_lvl !== ec) begin
      n_fail++;
      $display("FAIL %s com_lvl actual %h expected %h", tag, com_lvl, ec);
    end
    n_run++;
    if (seg_lvl !== es) begin
      n_fail++;
      $display("FAIL %s seg_lvl actual %h expected %h", tag, seg_lvl, es);
    end
  endtask

  task automatic wr(input int addr, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < NSEG) m_ram[addr] = d;
    else if (addr == NSEG) begin
      m_duty = d[0]; m_off = d[1]; m_port = d[2];
    end else if (addr == NSEG + 1) m_pdat = d;
  endtask

  task automatic tick();
    int last;
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    last = m_duty ? 3 : 2;
    if (m_slot >= last) begin
      m_slot = 0; m_odd ^= 1;
    end else m_slot++;
    for (int s = 0; s < NSEG; s++) m_lit[s] = m_ram[s][m_slot];
  endtask

  task automatic fill(input int kind);
    for (int s = 0; s < NSEG; s++) begin
      logic [3:0] d;
      case (kind)
        0: d = 4'(1 << (s % 4));
        1: d = 4'hF;
        2: d = 4'h0;
        default: d = (s % 2) ? 4'hA : 4'h5;
      endcase
      wr(s, d);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSEG; s++) m_ram[s] = '0;
    m_lit = '0; m_slot = 0; m_odd = 0; m_duty = 0; m_off = 0; m_port = 0; m_pdat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    // R4 R5 four-common scheme over several patterns
    wr(NSEG, 4'b0001);
    for (int k = 0; k < 4; k++) begin
      fill(k);
      for (int t = 0; t < 8; t++) begin
        tick();
        check("R4_R5 quarter duty scan");
      end
    end

    // R6 R7 three-common scheme; patterns set the COM4 bit
    wr(NSEG, 4'b0000);
    for (int k = 0; k < 4; k++) begin
      fill(k);
      for (int t = 0; t < 6; t++) begin
        tick();
        check("R6_R7 third duty scan");
      end
    end

    // R3 frame wrap timing across schemes
    for (int t = 0; t < 7; t++) begin
      tick();
      check("R3 slot sequence");
    end

    // R8 write during a slot has no effect until the next tick
    wr(NSEG, 4'b0001);
    fill(2);
    tick();
    for (int s = 0; s < NSEG; s++) wr(s, 4'hF);
    for (int s = 0; s < NSEG; s++) m_ram[s] = 4'hF;
    check("R8 mid-slot write held");
    tick();
    check("R8 captured at next tick");

    // R2 unused addresses change nothing
    for (int a = NSEG + 2; a < 32; a++) begin
      wr(a, 4'hF);
      check("R2 unused address");
    end
    tick();
    check("R2 after unused writes");

    // R9 display off while sequencing continues
    wr(NSEG, 4'b0011);
    check("R9 off blank");
    for (int t = 0; t < 5; t++) begin
      tick();
      check("R9 off during scan");
    end
    wr(NSEG, 4'b0001);
    check("R9 on again, sequence kept");

    // R10 port reuse, display on and off, both schemes
    for (int c = 0; c < 4; c++) begin
      wr(NSEG, 4'(4 | c));
      for (int p = 0; p < 16; p++) begin
        wr(NSEG + 1, 4'(p));
        check("R10 port segments");
      end
      tick();
      check("R10 port with scan");
    end
    wr(NSEG, 4'b0001);

    // R11 switch to three commons while in slot 3
    fill(3);
    while (m_slot != 3) tick();
    check("R11 at slot 3");
    wr(NSEG, 4'b0000);
    check("R11 scheme switched");
    tick();
    check("R11 wrap after switch");
    tick();
    check("R11 next slot");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule